// File: doc/BRIEF.md
# Palette Triplet Access Port

This block is the host-facing register port of a colour look-up table. The host picks a register with a 4-bit select code and performs single-byte reads and writes on it. Colour entries are moved as three bytes in a row, red first, then green, then blue. A small shared sequencer counts the bytes. The third byte of a write commits the whole entry and steps the write address. The third byte of a read steps the read index.

Two tables sit behind the port. The first is a main table of `PAL_DEPTH` entries. The second is a four-entry overlay table with its own data code. Both tables share the sequencer and the two index registers. Readback can be limited to 6-bit components or give full bytes. When the border link is enabled, a write to overlay entry 0 also loads the border colour output. A pixel read mask register is held for the pixel path and is readable by the host.

Top module: `ramdac_palette_port`

## Requirements
- R1: Select codes: 0x0 write index, 0x1 main data, 0x2 pixel mask, 0x3 read index, 0x4 overlay write index, 0x5 overlay data, 0x7 overlay read index. Reading 0x0 or 0x4 returns the low 8 bits of the write address. Reading 0x3 or 0x7 returns the 8-bit read index.
- R2: Data writes are taken at byte positions 0, 1 and 2 as red, green and blue. The blue byte stores {red, green, blue} into the entry at the write address modulo the table depth. It also adds 1 to the write address and returns the position to 0.
- R3: Data reads return red at position 0, green at position 1 and blue at position 2, from the entry at the read index. The blue read adds 1 to the 8-bit read index, wrapping at 0xFF, and returns the position to 0.
- R4: The overlay table has 4 entries, selected by bits [1:0] of the write address or of the read index. It uses the same position counter and the same index registers as the main table.
- R5: With `full_byte_mode` low, each component read back has bits [7:6] forced to 0. With it high, the stored byte is returned unchanged.
- R6: When `border_link_en` is high and an overlay write commits to entry 0, `border_rgb` takes {red, green, blue} on the next cycle. At all other times `border_rgb` holds its value.
- R7: `dac_state` reads 0 after reset and 3 from the cycle after any data read or write.
- R8: Writing any of the four index codes returns the position to 0. A write to 0x0 or 0x4 loads the 10-bit write address with the byte, upper bits cleared. A write to 0x3 or 0x7 loads only the separate read index.
- R9: The pixel mask resets to 0xFF, and a read of code 0x2 returns the last value written to it.
- R10: Codes 0x6 and 0x8 to 0xF read as 0xFF. Writes to them change no register, no table entry and no byte position.
- R11: After reset the position, both indices, all table entries and `border_rgb` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 4 | Register select code |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe (ignored while wr_en is high) |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the selected register (combinational) |
| full_byte_mode | input | 1 | 1: 8-bit component readback, 0: 6-bit |
| border_link_en | input | 1 | Lets overlay entry 0 writes load the border colour |
| dac_state | output | 2 | Access status field |
| border_rgb | output | 24 | Border colour {red, green, blue} |

## Verification
The bench builds the block with `PAL_DEPTH` = 16 and `ADDR_W` = 10. The small main table makes address aliasing common under random stimulus: an index such as 0x13 lands on entry 3. The 8-bit readback of the 10-bit write address can then be checked separately from the table index. A directed write at index 0xFF carries the write address past 8 bits, so the index readback wrapping to 0x00 is reached. Random traffic mixes reads and writes of every select code and toggles the mode and border-link inputs, so triplets get cut short by index writes and padded with writes to unused codes.

// File: rtl/ramdac_pkg.sv
package ramdac_pkg;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef enum logic [3:0] {
        SEL_WIDX  = 4'h0,
        SEL_DATA  = 4'h1,
        SEL_MASK  = 4'h2,
        SEL_RIDX  = 4'h3,
        SEL_XWIDX = 4'h4,
        SEL_XDATA = 4'h5,
        SEL_XRIDX = 4'h7
    } sel_e;

    localparam logic [1:0] POS_RED   = 2'd0;
    localparam logic [1:0] POS_GREEN = 2'd1;
    localparam logic [1:0] POS_BLUE  = 2'd2;

    localparam logic [1:0] STAT_IDLE = 2'd0;
    localparam logic [1:0] STAT_DATA = 2'd3;

    localparam logic [7:0] UNUSED_READ = 8'hFF;
    localparam logic [7:0] MASK_RESET  = 8'hFF;

    // Picks one component of an entry by byte position and applies the
    // readback depth (6-bit readback clears the top two bits).
    function automatic logic [7:0] pick_component(input rgb_t c,
                                                  input logic [1:0] pos,
                                                  input logic full);
        logic [7:0] v;
        case (pos)
            POS_RED:   v = c.r;
            POS_GREEN: v = c.g;
            default:   v = c.b;
        endcase
        return full ? v : {2'b00, v[5:0]};
    endfunction

endpackage

// File: rtl/ramdac_triplet_seq.sv
module ramdac_triplet_seq
    import ramdac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic       restart,
    input  logic [7:0] wdata,
    output logic [1:0] pos,
    output logic       commit,
    output rgb_t       commit_rgb,
    output logic       rd_last
);

    typedef struct packed {
        logic [1:0] pos;
        logic [7:0] red;
        logic [7:0] green;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.pos = POS_RED;
        end else if (data_wr) begin
            case (st_q.pos)
                POS_RED: begin
                    st_d.red = wdata;
                    st_d.pos = POS_GREEN;
                end
                POS_GREEN: begin
                    st_d.green = wdata;
                    st_d.pos   = POS_BLUE;
                end
                default: st_d.pos = POS_RED;
            endcase
        end else if (data_rd) begin
            st_d.pos = (st_q.pos == POS_BLUE) ? POS_RED : st_q.pos + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos        = st_q.pos;
    assign commit     = data_wr && !restart && (st_q.pos == POS_BLUE);
    assign commit_rgb = '{r: st_q.red, g: st_q.green, b: wdata};
    assign rd_last    = data_rd && !restart && (st_q.pos == POS_BLUE);

endmodule

// File: rtl/ramdac_pal_bank.sv
module ramdac_pal_bank
    import ramdac_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  rgb_t          wdata,
    input  logic [AW-1:0] raddr,
    output rgb_t          rdata
);

    rgb_t mem_d [DEPTH];
    rgb_t mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/ramdac_palette_port.sv
module ramdac_palette_port
    import ramdac_pkg::*;
#(
    parameter int PAL_DEPTH = 256,
    parameter int ADDR_W    = 10,
    localparam int PAL_AW   = $clog2(PAL_DEPTH),
    localparam int EXT_DEPTH = 4,
    localparam int EXT_AW   = $clog2(EXT_DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_sel,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic        full_byte_mode,
    input  logic        border_link_en,
    output logic [1:0]  dac_state,
    output logic [23:0] border_rgb
);

    typedef struct packed {
        logic [ADDR_W-1:0] wr_addr;
        logic [7:0]        rd_idx;
        logic [7:0]        pix_mask;
        logic [1:0]        status;
        rgb_t              border;
    } port_state_t;

    port_state_t st_d, st_q;

    // Access decode
    logic wr_ok, rd_ok;
    logic main_wr, ext_wr, main_rd, ext_rd;
    logic data_acc, idx_wr;

    assign wr_ok   = wr_en;
    assign rd_ok   = rd_en && !wr_en;
    assign main_wr = wr_ok && (reg_sel == SEL_DATA);
    assign ext_wr  = wr_ok && (reg_sel == SEL_XDATA);
    assign main_rd = rd_ok && (reg_sel == SEL_DATA);
    assign ext_rd  = rd_ok && (reg_sel == SEL_XDATA);
    assign data_acc = main_wr || ext_wr || main_rd || ext_rd;
    assign idx_wr  = wr_ok && ((reg_sel == SEL_WIDX)  || (reg_sel == SEL_RIDX) ||
                               (reg_sel == SEL_XWIDX) || (reg_sel == SEL_XRIDX));

    // Shared byte sequencer
    logic [1:0] seq_pos;
    logic       seq_commit;
    rgb_t       seq_rgb;
    logic       seq_rd_last;

    ramdac_triplet_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_wr    (main_wr || ext_wr),
        .data_rd    (main_rd || ext_rd),
        .restart    (idx_wr),
        .wdata      (wdata),
        .pos        (seq_pos),
        .commit     (seq_commit),
        .commit_rgb (seq_rgb),
        .rd_last    (seq_rd_last)
    );

    // Table banks: main and overlay share one module, sized by generate-free
    // parameterisation; each gets its own write enable.
    rgb_t main_rgb, ext_rgb;
    logic main_we, ext_we;

    assign main_we = seq_commit && main_wr;
    assign ext_we  = seq_commit && ext_wr;

    ramdac_pal_bank #(.DEPTH(PAL_DEPTH)) u_main_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (main_we),
        .waddr (st_q.wr_addr[PAL_AW-1:0]),
        .wdata (seq_rgb),
        .raddr (st_q.rd_idx[PAL_AW-1:0]),
        .rdata (main_rgb)
    );

    ramdac_pal_bank #(.DEPTH(EXT_DEPTH)) u_ext_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ext_we),
        .waddr (st_q.wr_addr[EXT_AW-1:0]),
        .wdata (seq_rgb),
        .raddr (st_q.rd_idx[EXT_AW-1:0]),
        .rdata (ext_rgb)
    );

    logic border_hit;
    assign border_hit = ext_we && border_link_en &&
                        (st_q.wr_addr[EXT_AW-1:0] == '0);

    // Next-state
    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            case (reg_sel)
                SEL_WIDX, SEL_XWIDX: st_d.wr_addr  = ADDR_W'(wdata);
                SEL_RIDX, SEL_XRIDX: st_d.rd_idx   = wdata;
                SEL_MASK:            st_d.pix_mask = wdata;
                default: ;
            endcase
        end
        if (seq_commit) begin
            st_d.wr_addr = st_q.wr_addr + ADDR_W'(1);
        end
        if (border_hit) begin
            st_d.border = seq_rgb;
        end
        if (seq_rd_last) begin
            st_d.rd_idx = st_q.rd_idx + 8'd1;
        end
        if (data_acc) begin
            st_d.status = STAT_DATA;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.pix_mask <= MASK_RESET;
            st_q.status   <= STAT_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Readback mux
    always_comb begin
        case (reg_sel)
            SEL_WIDX, SEL_XWIDX: rdata = st_q.wr_addr[7:0];
            SEL_RIDX, SEL_XRIDX: rdata = st_q.rd_idx;
            SEL_MASK:            rdata = st_q.pix_mask;
            SEL_DATA:            rdata = pick_component(main_rgb, seq_pos, full_byte_mode);
            SEL_XDATA:           rdata = pick_component(ext_rgb, seq_pos, full_byte_mode);
            default:             rdata = UNUSED_READ;
        endcase
    end

    logic [ADDR_W-1:0] wr_addr_cur;
    logic [7:0]        rd_idx_cur;

    assign wr_addr_cur = st_q.wr_addr;
    assign rd_idx_cur  = st_q.rd_idx;
    assign dac_state   = st_q.status;
    assign border_rgb  = st_q.border;

endmodule

// File: rtl/ramdac_port_chk.sv
module ramdac_port_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        pos,
    input logic              data_acc,
    input logic              idx_wr,
    input logic [1:0]        status,
    input logic [23:0]       border_rgb,
    input logic              border_hit,
    input logic              commit,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rd_last,
    input logic [7:0]        rd_idx
);

    // R2: the byte position never reaches the unused value 3
    p_pos_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pos != 2'd3);

    // R2: a committed entry advances the write address by one
    p_commit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> wr_addr == ADDR_W'($past(wr_addr) + ADDR_W'(1)));

    // R3: the last read of a triplet advances the read index by one
    p_read_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |=> rd_idx == 8'($past(rd_idx) + 8'd1));

    // R6: border colour moves only on an enabled overlay entry 0 commit
    p_border_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !border_hit |=> $stable(border_rgb));

    // R7: status field shows 3 after any data access
    p_status_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc |=> status == 2'd3);

    // R8: an index write restarts the triplet
    p_restart_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> pos == 2'd0);

endmodule

bind ramdac_palette_port ramdac_port_chk #(.ADDR_W(ADDR_W)) u_port_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pos        (seq_pos),
    .data_acc   (data_acc),
    .idx_wr     (idx_wr),
    .status     (dac_state),
    .border_rgb (border_rgb),
    .border_hit (border_hit),
    .commit     (seq_commit),
    .wr_addr    (wr_addr_cur),
    .rd_last    (seq_rd_last),
    .rd_idx     (rd_idx_cur)
);

// File: tb/tb_ramdac_palette_port.sv
module tb_ramdac_palette_port;

    localparam int DEPTH  = 16;
    localparam int ADDR_W = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        full_byte_mode = 1'b1;
    logic        border_link_en = 1'b0;
    logic [1:0]  dac_state;
    logic [23:0] border_rgb;

    ramdac_palette_port #(.PAL_DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_sel        (reg_sel),
        .wr_en          (wr_en),
        .rd_en          (rd_en),
        .wdata          (wdata),
        .rdata          (rdata),
        .full_byte_mode (full_byte_mode),
        .border_link_en (border_link_en),
        .dac_state      (dac_state),
        .border_rgb     (border_rgb)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Reference model
    logic [23:0]       m_main [DEPTH];
    logic [23:0]       m_ext  [4];
    logic [ADDR_W-1:0] m_wa;
    logic [7:0]        m_ri, m_mask, m_r, m_g;
    logic [1:0]        m_pos, m_stat;
    logic [23:0]       m_border;

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_main[i] = '0;
        for (int i = 0; i < 4; i++) m_ext[i] = '0;
        m_wa = '0; m_ri = '0; m_mask = 8'hFF; m_r = '0; m_g = '0;
        m_pos = '0; m_stat = '0; m_border = '0;
    endtask

    function automatic logic [7:0] comp(input logic [23:0] c, input logic [1:0] p,
                                        input logic full);
        logic [7:0] v;
        v = (p == 2'd0) ? c[23:16] : (p == 2'd1) ? c[15:8] : c[7:0];
        return full ? v : {2'b00, v[5:0]};
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] s);
        case (s)
            4'h0, 4'h4: return m_wa[7:0];
            4'h3, 4'h7: return m_ri;
            4'h2:       return m_mask;
            4'h1:       return comp(m_main[m_ri % DEPTH], m_pos, full_byte_mode);
            4'h5:       return comp(m_ext[m_ri[1:0]], m_pos, full_byte_mode);
            default:    return 8'hFF;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic host_wr(input logic [3:0] s, input logic [7:0] v);
        @(negedge clk);
        reg_sel = s; wdata = v; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
        case (s)
            4'h0, 4'h4: begin m_wa = ADDR_W'(v); m_pos = 0; end
            4'h3, 4'h7: begin m_ri = v; m_pos = 0; end
            4'h2: m_mask = v;
            4'h1, 4'h5: begin
                m_stat = 2'd3;
                if (m_pos == 0) begin m_r = v; m_pos = 1; end
                else if (m_pos == 1) begin m_g = v; m_pos = 2; end
                else begin
                    if (s == 4'h1) m_main[m_wa % DEPTH] = {m_r, m_g, v};
                    else begin
                        m_ext[m_wa[1:0]] = {m_r, m_g, v};
                        if (border_link_en && m_wa[1:0] == 2'd0) m_border = {m_r, m_g, v};
                    end
                    m_wa = m_wa + 1'b1;
                    m_pos = 0;
                end
            end
            default: ;
        endcase
    endtask

    task automatic host_rd(input logic [3:0] s, input string req);
        @(negedge clk);
        reg_sel = s; rd_en = 1'b1;
        #1 chk(req, {24'd0, rdata}, {24'd0, exp_read(s)});
        @(posedge clk);
        #1 rd_en = 1'b0;
        if (s == 4'h1 || s == 4'h5) begin
            m_stat = 2'd3;
            if (m_pos == 2) begin m_pos = 0; m_ri = m_ri + 1'b1; end
            else m_pos = m_pos + 1'b1;
        end
    endtask

    task automatic chk_side(input string req_s, input string req_b);
        @(negedge clk);
        chk(req_s, {30'd0, dac_state}, {30'd0, m_stat});
        chk(req_b, {8'd0, border_rgb}, {8'd0, m_border});
    endtask

    task automatic wr_triplet(input logic [3:0] s, input logic [23:0] c);
        host_wr(s, c[23:16]); host_wr(s, c[15:8]); host_wr(s, c[7:0]);
    endtask

    task automatic rd_triplet(input logic [3:0] s, input string req);
        host_rd(s, req); host_rd(s, req); host_rd(s, req);
    endtask

    initial begin
        #(200000 * 10);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state, R9 mask reset
        chk_side("R7", "R11");
        host_rd(4'h2, "R9");
        host_rd(4'h0, "R11");
        host_rd(4'h3, "R11");
        host_rd(4'h1, "R11");
        host_wr(4'h3, 8'h00);

        // R2 / R3 / R1: main write then read
        host_wr(4'h0, 8'h05);
        wr_triplet(4'h1, 24'hC1_82_F3);
        host_rd(4'h0, "R2");
        host_wr(4'h3, 8'h05);
        rd_triplet(4'h1, "R3");
        host_rd(4'h3, "R3");
        chk_side("R7", "R6");

        // R5 six-bit readback
        full_byte_mode = 1'b0;
        host_wr(4'h3, 8'h05);
        rd_triplet(4'h1, "R5");
        full_byte_mode = 1'b1;

        // R4 overlay addressing by low bits
        host_wr(4'h4, 8'h06);
        wr_triplet(4'h5, 24'h11_22_33);
        host_wr(4'h7, 8'h0E);
        rd_triplet(4'h5, "R4");
        host_rd(4'h7, "R4");

        // R6 border link
        border_link_en = 1'b1;
        host_wr(4'h4, 8'h04);
        wr_triplet(4'h5, 24'hAB_CD_EF);
        chk_side("R7", "R6");
        border_link_en = 1'b0;
        host_wr(4'h4, 8'h00);
        wr_triplet(4'h5, 24'h01_02_03);
        chk_side("R7", "R6");

        // R8 index write restarts a triplet
        host_wr(4'h0, 8'h02);
        host_wr(4'h1, 8'h77);
        host_wr(4'h1, 8'h66);
        host_wr(4'h0, 8'h09);
        wr_triplet(4'h1, 24'h3C_5A_96);
        host_wr(4'h7, 8'h09);
        rd_triplet(4'h1, "R8");
        host_wr(4'h3, 8'h02);
        rd_triplet(4'h1, "R8");

        // R10 unused codes in the middle of a triplet
        host_wr(4'h2, 8'h5A);
        host_wr(4'h0, 8'h07);
        host_wr(4'h1, 8'h10);
        host_wr(4'h6, 8'hEE);
        host_wr(4'h8, 8'hDD);
        host_wr(4'hF, 8'hCC);
        host_wr(4'h1, 8'h20);
        host_wr(4'h1, 8'h30);
        host_rd(4'h6, "R10");
        host_rd(4'hB, "R10");
        host_rd(4'h2, "R10");
        host_rd(4'h0, "R10");
        host_wr(4'h3, 8'h07);
        rd_triplet(4'h1, "R10");

        // R2 write address carries past 8 bits
        host_wr(4'h0, 8'hFF);
        wr_triplet(4'h1, 24'h0F_1E_2D);
        host_rd(4'h0, "R2");
        host_wr(4'h3, 8'h0F);
        rd_triplet(4'h1, "R2");

        // Random mix, R1
        for (int n = 0; n < 1500; n++) begin
            logic [3:0] s;
            int k;
            k = $urandom_range(0, 19);
            s = (k < 16) ? k[3:0] : ((k & 1) ? 4'h1 : 4'h5);
            if ($urandom_range(0, 15) == 0) full_byte_mode = ~full_byte_mode;
            if ($urandom_range(0, 15) == 0) border_link_en = ~border_link_en;
            if ($urandom_range(0, 1) == 0) host_wr(s, 8'($urandom));
            else host_rd(s, "R1");
            if (n % 100 == 0) chk_side("R7", "R6");
        end
        chk_side("R7", "R6");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule